// File: doc/BRIEF.md
# Partitioned Byte-Wide SRAM Bus Controller

This block connects an 8-bit processor core to external battery-backed byte-wide SRAM. The core issues 16-bit code fetches and data reads and writes. The controller turns each request into one access on a dedicated bus. That bus has a 15-bit address, an 8-bit data path with separate in, out and output-enable signals, two active-low device selects and a read/write line, so no general-purpose port pins are consumed.

A partition value, counted in 1 kB blocks, splits the primary device into two parts. The low part holds code and is fetched at its own address. The high part holds data, and a data address is placed there by adding the boundary to it. A secondary 32 kB device is reached only by data accesses with the top address bit set. Writes aimed at code space never reach a device and set a sticky violation flag. The partition can only be written right after an unlock key sequence, and a new value takes effect only between bus cycles.

Every access takes the same number of cycles, whether or not it reaches a device. A read drives the select for `ACC_CYC` cycles. A write adds one quiet cycle before the strobe and one after it, so the data drivers never overlap a device that is driving the bus.

Top module: `nvbus_part_ctrl`

## Requirements
- R1: A code read below the boundary (partition × 1024) selects the primary device at the same address. A code read at or above the boundary asserts no select and returns 0xFF.
- R2: A data access with address bit 15 clear goes to primary address boundary + address when that sum is below 32768. Otherwise it asserts no select, and a read returns 0xFF.
- R3: A data access with address bit 15 set selects only the secondary device, at address bits 14:0. Code requests never select it, and the two selects are never low together.
- R4: Bus address bits 14 and 13 carry the inverse of the physical address bits, while bits 12:0 are driven true.
- R5: A write request marked as code asserts no select, keeps the read/write line high and sets the violation flag.
- R6: The violation flag stays set until `viol_clr` is pulsed. If a new code write is accepted in the same cycle as the clear, the flag ends up set.
- R7: A partition write is accepted only within the 4 cycles after a key write of 0xAA that is immediately followed, in the next cycle, by a key write of 0x55. An accepted write closes the window. Values above 32 are stored as 32.
- R8: The active partition does not change while a bus cycle is in progress. A value written during an access is applied after that access ends, and the access uses the old mapping.
- R9: A read holds its select low with the read/write line high for `ACC_CYC` cycles, never enables the data drivers, then pulses `rsp_done` for one cycle with the read byte on `rsp_rdata`.
- R10: A write spends one cycle with no select and no drive. It then spends `ACC_CYC` cycles with the select low, the read/write line low, drivers on and the write byte on `bd_o`, followed by one more cycle with no select and no drive.
- R11: After reset, both selects and the read/write line are high, the drivers are off, the violation flag is clear, `req_ready` is high and the partition equals `PART_RST` (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_code | input | 1 | 1 = code space, 0 = data space |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Logical address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with `rsp_done` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_key | input | 1 | 1 = key write, 0 = partition write |
| cfg_wdata | input | 8 | Key byte or partition value |
| part_o | output | 6 | Active partition, in 1 kB blocks |
| viol_o | output | 1 | Sticky code-write violation flag |
| viol_clr | input | 1 | Clears the violation flag |
| ba | output | 15 | SRAM address bus (bits 14:13 inverted) |
| bd_o | output | 8 | SRAM data out |
| bd_i | input | 8 | SRAM data in |
| bd_oe | output | 1 | Data driver enable |
| ce1_n | output | 1 | Primary device select, active low |
| ce2_n | output | 1 | Secondary device select, active low |
| rw_n | output | 1 | High = read, low = write |

## Verification
Two events can meet in one clock edge. A suppressed code write can set the violation flag in the same cycle that software pulses the clear. The bench provokes this by raising `viol_clr` in the same cycle as the code-write request, then expects the flag to read set once the access completes. A second overlap puts a partition write in the same cycle as the acceptance of a data read. The bench watches `part_o` on every cycle of that read and expects it unchanged. It also expects the returned byte to come from the address given by the old boundary, and the new value to appear two cycles after completion.

// File: rtl/nvbus_part_ctrl.sv
`timescale 1ns/1ps
module nvbus_part_ctrl #(
  parameter int         PRI_AW     = 15,
  parameter int         GRAN_AW    = 10,
  parameter int         ACC_CYC    = 2,
  parameter int         UNLOCK_CYC = 4,
  parameter int         PART_RST   = 16,
  parameter logic [7:0] KEY_A      = 8'hAA,
  parameter logic [7:0] KEY_B      = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_code,
  input  logic        req_we,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_done,
  output logic [7:0]  rsp_rdata,
  input  logic        cfg_we,
  input  logic        cfg_key,
  input  logic [7:0]  cfg_wdata,
  output logic [PRI_AW-GRAN_AW:0] part_o,
  output logic        viol_o,
  input  logic        viol_clr,
  output logic [14:0] ba,
  output logic [7:0]  bd_o,
  input  logic [7:0]  bd_i,
  output logic        bd_oe,
  output logic        ce1_n,
  output logic        ce2_n,
  output logic        rw_n
);
  localparam int PW       = PRI_AW - GRAN_AW + 1;
  localparam int PART_MAX = 1 << (PRI_AW - GRAN_AW);
  localparam int CW       = $clog2(ACC_CYC + 1);
  localparam int UW       = $clog2(UNLOCK_CYC + 1);
  localparam logic [16:0] PRI_SIZE = 17'(1 << PRI_AW);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WS, S_WP, S_WH} state_t;
  typedef enum logic [1:0] {T_NONE, T_PRI, T_SEC} tgt_t;

  state_t          state_q;
  tgt_t            tgt_q, tgt_n;
  logic [14:0]     phys_q, phys_n;
  logic [7:0]      wdata_q, rdata_q;
  logic            we_q, code_q, done_q, viol_q, arm_q;
  logic [CW-1:0]   cnt_q;
  logic [UW-1:0]   ucnt_q;
  logic [PW-1:0]   pend_q, part_q, part_in;
  logic [16:0]     bound, data_sum;
  logic            accept, last_beat, part_wr, key_open;

  assign accept    = req_valid && (state_q == S_IDLE);
  assign last_beat = (cnt_q == CW'(ACC_CYC - 1));
  assign bound     = 17'(part_q) << GRAN_AW;
  assign data_sum  = bound + {1'b0, req_addr};

  always_comb begin
    tgt_n  = T_NONE;
    phys_n = req_addr[14:0];
    if (req_code) begin
      if (!req_we && ({1'b0, req_addr} < bound)) tgt_n = T_PRI;
    end else if (req_addr[15]) begin
      tgt_n = T_SEC;
    end else if (data_sum < PRI_SIZE) begin
      tgt_n  = T_PRI;
      phys_n = data_sum[14:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tgt_q   <= T_NONE;
      phys_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      code_q  <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          tgt_q   <= tgt_n;
          phys_q  <= phys_n;
          wdata_q <= req_wdata;
          we_q    <= req_we;
          code_q  <= req_code;
          cnt_q   <= '0;
          state_q <= req_we ? S_WS : S_RD;
        end
        S_RD: if (last_beat) begin
          rdata_q <= (tgt_q == T_NONE) ? 8'hFF : bd_i;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        S_WS: begin
          cnt_q   <= '0;
          state_q <= S_WP;
        end
        S_WP: if (last_beat) state_q <= S_WH;
              else cnt_q <= cnt_q + 1'b1;
        S_WH: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= (viol_q && !viol_clr) || (accept && req_code && req_we);
  end

  assign key_open = cfg_we && cfg_key && (cfg_wdata == KEY_B) && arm_q;
  assign part_wr  = cfg_we && !cfg_key && (ucnt_q != '0);
  assign part_in  = (cfg_wdata > 8'(PART_MAX)) ? PW'(PART_MAX) : PW'(cfg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      ucnt_q <= '0;
      pend_q <= PW'(PART_RST);
      part_q <= PW'(PART_RST);
    end else begin
      arm_q <= cfg_we && cfg_key && (cfg_wdata == KEY_A);
      if (key_open)            ucnt_q <= UW'(UNLOCK_CYC);
      else if (part_wr)        ucnt_q <= '0;
      else if (ucnt_q != '0)   ucnt_q <= ucnt_q - 1'b1;
      if (part_wr) pend_q <= part_in;
      if (state_q == S_IDLE) part_q <= pend_q;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign part_o    = part_q;
  assign viol_o    = viol_q;
  assign ba        = phys_q ^ 15'h6000;
  assign bd_o      = wdata_q;
  assign ce1_n     = !(((state_q == S_RD) || (state_q == S_WP)) && (tgt_q == T_PRI));
  assign ce2_n     = !(((state_q == S_RD) || (state_q == S_WP)) && (tgt_q == T_SEC));
  assign rw_n      = !((state_q == S_WP) && (tgt_q != T_NONE));
  assign bd_oe     = (state_q == S_WP) && (tgt_q != T_NONE);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce1_n && !ce2_n));
  p_code_write_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) && code_q && we_q |-> rw_n && ce1_n && ce2_n);
  p_drive_in_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bd_oe |-> !rw_n && !(ce1_n && ce2_n));
  p_drive_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bd_oe) |-> $past(ce1_n && ce2_n && rw_n));
  p_viol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q && !viol_clr |=> viol_q);
  p_part_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(part_q));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) && $past(state_q != S_IDLE) |-> $stable(ba));
endmodule

// File: tb/nvbus_part_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvbus_part_ctrl_tb_top;
  localparam int ACC = 2;

  typedef struct packed {
    logic        code;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [1:0]  sel;
    logic [14:0] phys;
    logic        viol;
  } vec_t;

  // sel: 0 none, 1 primary, 2 secondary; partition 16 -> boundary 0x4000
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 16'h0123, 8'h00, 2'd1, 15'h0123, 1'b0},
    '{1'b1, 1'b0, 16'h3FFF, 8'h00, 2'd1, 15'h3FFF, 1'b0},
    '{1'b1, 1'b0, 16'h4000, 8'h00, 2'd0, 15'h0000, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 8'h00, 2'd1, 15'h4000, 1'b0},
    '{1'b0, 1'b0, 16'h3FFF, 8'h00, 2'd1, 15'h7FFF, 1'b0},
    '{1'b0, 1'b0, 16'h4000, 8'h00, 2'd0, 15'h0000, 1'b0},
    '{1'b0, 1'b0, 16'h8000, 8'h00, 2'd2, 15'h0000, 1'b0},
    '{1'b0, 1'b0, 16'hFFFF, 8'h00, 2'd2, 15'h7FFF, 1'b0},
    '{1'b0, 1'b1, 16'h0010, 8'h3C, 2'd1, 15'h4010, 1'b0},
    '{1'b0, 1'b1, 16'h9234, 8'hA5, 2'd2, 15'h1234, 1'b0},
    '{1'b1, 1'b1, 16'h0100, 8'h77, 2'd0, 15'h0000, 1'b1},
    '{1'b0, 1'b1, 16'h7000, 8'h11, 2'd0, 15'h0000, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_code = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, cfg_wdata = '0;
  logic cfg_we = 1'b0, cfg_key = 1'b0, viol_clr = 1'b0;
  logic req_ready, rsp_done, viol_o, bd_oe, ce1_n, ce2_n, rw_n;
  logic [7:0] rsp_rdata, bd_o, bd_i;
  logic [5:0] part_o;
  logic [14:0] ba;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int n_ce1, n_ce2, n_rw, n_oe, ba_bad, bd_bad, gap_bad, part_chg;
  bit got_done;
  logic [7:0] rd_val;

  always #2 clk = ~clk;

  function automatic logic [7:0] model(input logic [14:0] a, input logic sec);
    return a[7:0] ^ {1'b0, a[14:8]} ^ (sec ? 8'hC3 : 8'h00);
  endfunction

  assign bd_i = (rw_n && !(ce1_n && ce2_n)) ? model(ba, !ce2_n) : 8'h00;

  nvbus_part_ctrl #(.ACC_CYC(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_key(cfg_key),
    .cfg_wdata(cfg_wdata), .part_o(part_o), .viol_o(viol_o), .viol_clr(viol_clr),
    .ba(ba), .bd_o(bd_o), .bd_i(bd_i), .bd_oe(bd_oe), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .rw_n(rw_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic key, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_key = key; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic unlock();
    cfg_wr(1'b1, 8'hAA);
    cfg_wr(1'b1, 8'h55);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_access(input logic code, input logic we, input logic [15:0] addr,
                            input logic [7:0] wd, input logic clr, input logic [14:0] exp_ba,
                            input logic cfg_en, input logic [7:0] cfg_d);
    logic prev_oe, prev_ce, ce_any;
    logic [5:0] part0;
    n_ce1 = 0; n_ce2 = 0; n_rw = 0; n_oe = 0; ba_bad = 0; bd_bad = 0; gap_bad = 0;
    part_chg = 0; got_done = 0; prev_oe = 0; prev_ce = 0;
    @(negedge clk);
    part0 = part_o;
    req_valid = 1'b1; req_code = code; req_we = we; req_addr = addr; req_wdata = wd;
    viol_clr = clr;
    if (cfg_en) begin cfg_we = 1'b1; cfg_key = 1'b0; cfg_wdata = cfg_d; end
    @(posedge clk); #1;
    req_valid = 1'b0; viol_clr = 1'b0; cfg_we = 1'b0;
    for (int i = 0; i < 20 && !got_done; i++) begin
      @(negedge clk);
      ce_any = !ce1_n || !ce2_n;
      if (!ce1_n) n_ce1++;
      if (!ce2_n) n_ce2++;
      if (!rw_n) n_rw++;
      if (bd_oe) begin n_oe++; if (bd_o !== wd) bd_bad++; end
      if (ce_any && ba !== exp_ba) ba_bad++;
      if (bd_oe && !prev_oe && prev_ce) gap_bad++;
      if (!bd_oe && prev_oe && ce_any) gap_bad++;
      if (part_o !== part0) part_chg++;
      prev_oe = bd_oe; prev_ce = ce_any;
      if (rsp_done) got_done = 1;
    end
    rd_val = rsp_rdata;
  endtask

  task automatic check_result(input string req, input logic we, input logic [1:0] sel,
                              input logic [14:0] phys, input logic [7:0] wd);
    chk("R9", {req, " done"}, got_done, 1);
    chk(req, "ce1 cycles", n_ce1, (sel == 2'd1) ? ACC : 0);
    chk("R3", "ce2 cycles", n_ce2, (sel == 2'd2) ? ACC : 0);
    chk("R4", "address", ba_bad, 0);
    if (we) begin
      chk("R10", "strobe cycles", n_rw, (sel != 2'd0) ? ACC : 0);
      chk("R10", "drive cycles", n_oe, (sel != 2'd0) ? ACC : 0);
      chk("R10", "drive gap", gap_bad, 0);
      chk("R10", "write byte", bd_bad, 0);
    end else begin
      chk("R9", "read strobe", n_rw + n_oe, 0);
      chk(req, "read byte", rd_val, (sel == 2'd0) ? 8'hFF : model(phys ^ 15'h6000, sel == 2'd2));
    end
    if (wd == 8'hFE) chk(req, "unused", 0, 1);
  endtask

  task automatic acc(input string req, input logic code, input logic we, input logic [15:0] addr,
                     input logic [7:0] wd, input logic [1:0] sel, input logic [14:0] phys);
    run_access(code, we, addr, wd, 1'b0, phys ^ 15'h6000, 1'b0, 8'h00);
    check_result(req, we, sel, phys, wd);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog R9 actual=hung expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "ce1_n", ce1_n, 1);
    chk("R11", "ce2_n", ce2_n, 1);
    chk("R11", "rw_n", rw_n, 1);
    chk("R11", "bd_oe", bd_oe, 0);
    chk("R11", "viol", viol_o, 0);
    chk("R11", "ready", req_ready, 1);
    chk("R11", "partition", part_o, 16);

    for (int i = 0; i < 12; i++) begin
      string tag;
      tag = VEC[i].code ? (VEC[i].we ? "R5" : "R1") : (VEC[i].addr[15] ? "R3" : "R2");
      acc(tag, VEC[i].code, VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].sel, VEC[i].phys);
      chk(tag, $sformatf("viol after vec %0d", i), viol_o, VEC[i].viol);
    end

    // R6 clear, then set and clear in the same cycle
    @(negedge clk); viol_clr = 1'b1;
    @(posedge clk); #1 viol_clr = 1'b0;
    @(negedge clk);
    chk("R6", "viol cleared", viol_o, 0);
    run_access(1'b1, 1'b1, 16'h0010, 8'h5A, 1'b1, 15'h0, 1'b0, 8'h00);
    chk("R6", "set wins over clear", viol_o, 1);
    chk("R5", "no strobe on code write", n_rw + n_ce1 + n_ce2, 0);

    // R7 timed access
    cfg_wr(1'b0, 8'd8); settle();
    chk("R7", "write without key", part_o, 16);
    unlock(); cfg_wr(1'b0, 8'd8); settle();
    chk("R7", "write after key", part_o, 8);
    acc("R1", 1'b1, 1'b0, 16'h2000, 8'h00, 2'd0, 15'h0000);
    acc("R2", 1'b0, 1'b0, 16'h0000, 8'h00, 2'd1, 15'h2000);
    cfg_wr(1'b1, 8'hAA); @(posedge clk); cfg_wr(1'b1, 8'h55); cfg_wr(1'b0, 8'd20); settle();
    chk("R7", "split key", part_o, 8);
    unlock(); repeat (4) @(posedge clk); cfg_wr(1'b0, 8'd20); settle();
    chk("R7", "window expired", part_o, 8);
    unlock(); repeat (3) @(posedge clk); cfg_wr(1'b0, 8'd12); settle();
    chk("R7", "last window cycle", part_o, 12);
    unlock(); cfg_wr(1'b0, 8'd40); settle();
    chk("R7", "clamp", part_o, 32);
    acc("R2", 1'b0, 1'b0, 16'h0000, 8'h00, 2'd0, 15'h0000);
    acc("R1", 1'b1, 1'b0, 16'h7FFF, 8'h00, 2'd1, 15'h7FFF);
    unlock(); cfg_wr(1'b0, 8'd0); settle();
    chk("R7", "zero partition", part_o, 0);
    acc("R1", 1'b1, 1'b0, 16'h0000, 8'h00, 2'd0, 15'h0000);
    acc("R2", 1'b0, 1'b0, 16'h7FFF, 8'h00, 2'd1, 15'h7FFF);

    // R8 partition written in the cycle a read is accepted
    unlock();
    run_access(1'b0, 1'b0, 16'h0005, 8'h00, 1'b0, 15'h0005 ^ 15'h6000, 1'b1, 8'd4);
    chk("R8", "stable during access", part_chg, 0);
    chk("R8", "old mapping used", rd_val, model(15'h0005 ^ 15'h6000, 1'b0));
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8", "applied after access", part_o, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule